// File: doc/BRIEF.md
# Five-Stage Pipelined Processor Core

This block is a small in-order processor with five stages: fetch, decode, execute, memory access and writeback. It runs a 32-bit instruction set of seven operations: add, nor, load word, store word, branch-if-equal, halt and no-operation. It has eight 32-bit general registers. Instruction memory and data memory are both arrays inside the block. Each array is written on the clock edge and read combinationally. Stage registers sit between the stages. A fifth stage register after writeback keeps the last retired result so that it can still be forwarded.

To use the block, hold `rst_n` low and write the program and the initial data through the load port. Then release reset. The core runs until a halt instruction retires. The sequencing state machine has two states. In `ST_RUN` the pipeline advances on every clock. The transition `ST_RUN -> ST_HALT` is taken on the edge where a halt sits in the writeback stage. `ST_HALT` has no exit except reset. After halting, a combinational debug port reads back the registers, the data memory and the instruction memory.

Top module: `pipe5_core`

## Requirements
- R1: While `rst_n` is low and on its release, `halted` reads 0, `cycle_count` reads 0, and every register reads 0 through the debug port.
- R2: Instruction fields are fixed:
  - Opcode is in bits 24..22. First source register is in 21..19. Second source register is in 18..16. The add/nor destination is in 2..0. The 16-bit offset is in 15..0.
  - Codes are: add 000, nor 001, lw 010, sw 011, beq 100, halt 110, noop 111. Code 101 behaves as noop.
  - add writes the sum of the two sources. nor writes the bitwise NOR of the two sources.
- R3: lw writes the second-source register with data memory at (first source + sign-extended offset). sw stores the second source there. The address wraps modulo the memory depth.
- R4: Results of add, nor and lw are visible to a consumer 1, 2 or 3 instructions later without waiting. For add/nor at distance 1 there is no extra cycle.
- R5: If the instruction right after an lw reads that lw's destination, exactly one bubble is inserted, and the consumer then sees the loaded value.
- R6: Branches are predicted not taken, and a not-taken beq costs nothing.
  - A taken beq redirects to (its address + 1 + sign-extended offset) once it reaches the execute/memory register.
  - The three younger instructions are turned into noop, so they change no register or memory, including a halt among them.
- R7: `halted` rises on the edge after a halt reaches writeback, not earlier. From then on the PC and all state hold. Nothing fetched after a halt changes any state.
- R8: `cycle_count` counts clock edges from reset release up to and including the edge that raises `halted`, and holds afterwards.
- R9: Load port writes take effect only while `rst_n` is low. `prog_dmem` = 1 selects data memory and 0 selects instruction memory. Writes while running are ignored.
- R10: The debug port is combinational:
  - `dbg_sel` 0 returns register `dbg_addr[2:0]`.
  - `dbg_sel` 1 returns data memory.
  - `dbg_sel` 2 returns instruction memory.
  - `dbg_sel` 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; load window |
| prog_we | input | 1 | Load port write strobe |
| prog_dmem | input | 1 | Load target: 1 data memory, 0 instruction memory |
| prog_addr | input | MEM_AW | Load word address |
| prog_wdata | input | 32 | Load data |
| dbg_sel | input | 2 | Debug source select |
| dbg_addr | input | MEM_AW | Debug word or register address |
| dbg_rdata | output | 32 | Debug read data |
| halted | output | 1 | Core has retired a halt |
| cycle_count | output | CNT_W | Edges spent running |

## Verification
A wrong forwarding choice or a missed stall leaves a wrong value in a register or a memory word. It stays hidden until the debug port is read after `halted`. The programs therefore chain every result into later ones, so a single wrong operand changes the final state.

A miscounted bubble or flush, or a halt that acts too early, shows as a `cycle_count` that differs from the hand-derived edge count. It appears on the first edge where `halted` should or should not have risen. A branch that is wrongly taken or not taken also changes which stores land, and memory words that must stay untouched expose it.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

    localparam int REG_COUNT = 8;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_NOR  = 3'b001,
        OP_LW   = 3'b010,
        OP_SW   = 3'b011,
        OP_BEQ  = 3'b100,
        OP_RSVD = 3'b101,
        OP_HALT = 3'b110,
        OP_NOOP = 3'b111
    } op_e;

    typedef enum logic {
        ST_RUN,
        ST_HALT
    } core_state_e;

    localparam logic [31:0] NOOP_WORD = 32'h01C0_0000;

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] pc1;
    } ifid_t;

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] pc1;
        logic [31:0] rega;
        logic [31:0] regb;
        logic [31:0] offs;
    } idex_t;

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] target;
        logic [31:0] alu;
        logic [31:0] regb;
    } exmem_t;

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] wdata;
    } wb_t;

    function automatic op_e op_of(input logic [31:0] w);
        return op_e'(w[24:22]);
    endfunction

    function automatic logic [2:0] ra_of(input logic [31:0] w);
        return w[21:19];
    endfunction

    function automatic logic [2:0] rb_of(input logic [31:0] w);
        return w[18:16];
    endfunction

    function automatic logic [31:0] sext16(input logic [31:0] w);
        return {{16{w[15]}}, w[15:0]};
    endfunction

    function automatic logic writes_reg(input logic [31:0] w);
        return (op_of(w) == OP_ADD) || (op_of(w) == OP_NOR) || (op_of(w) == OP_LW);
    endfunction

    function automatic logic [2:0] dest_of(input logic [31:0] w);
        return (op_of(w) == OP_LW) ? rb_of(w) : w[2:0];
    endfunction

    function automatic logic reads_a(input logic [31:0] w);
        return (op_of(w) == OP_ADD) || (op_of(w) == OP_NOR) || (op_of(w) == OP_LW) ||
               (op_of(w) == OP_SW) || (op_of(w) == OP_BEQ);
    endfunction

    function automatic logic reads_b(input logic [31:0] w);
        return (op_of(w) == OP_ADD) || (op_of(w) == OP_NOR) ||
               (op_of(w) == OP_SW) || (op_of(w) == OP_BEQ);
    endfunction

endpackage

// File: rtl/core_ram.sv
module core_ram #(
    parameter int AW = 6,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata,
    input  logic [AW-1:0] daddr,
    output logic [31:0]   ddata
);

    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
    assign ddata = mem[daddr];

endmodule

// File: rtl/core_regfile.sv
module core_regfile
    import pipe5_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [2:0]  waddr,
    input  logic [31:0] wdata,
    input  logic [2:0]  ra_a,
    output logic [31:0] rd_a,
    input  logic [2:0]  ra_b,
    output logic [31:0] rd_b,
    input  logic [2:0]  ra_d,
    output logic [31:0] rd_d
);

    logic [31:0] regs [REG_COUNT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];
    assign rd_d = regs[ra_d];

endmodule

// File: rtl/core_hazard.sv
module core_hazard
    import pipe5_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ifid_instr,
    input  logic [31:0] idex_instr,
    input  logic [31:0] idex_rega,
    input  logic [31:0] idex_regb,
    input  logic [31:0] exmem_instr,
    input  logic [31:0] exmem_alu,
    input  logic [31:0] memwb_instr,
    input  logic [31:0] memwb_data,
    input  logic [31:0] wbend_instr,
    input  logic [31:0] wbend_data,
    output logic [31:0] val_a,
    output logic [31:0] val_b,
    output logic        stall
);

    logic [2:0]  src_reg [2];
    logic [31:0] src_val [2];
    logic [31:0] fwd_val [2];

    assign src_reg[0] = ra_of(idex_instr);
    assign src_reg[1] = rb_of(idex_instr);
    assign src_val[0] = idex_rega;
    assign src_val[1] = idex_regb;

    // youngest producer wins: EX/MEM, then MEM/WB, then WB/END
    for (genvar k = 0; k < 2; k++) begin : g_fwd
        always_comb begin
            if (writes_reg(exmem_instr) && dest_of(exmem_instr) == src_reg[k])
                fwd_val[k] = exmem_alu;
            else if (writes_reg(memwb_instr) && dest_of(memwb_instr) == src_reg[k])
                fwd_val[k] = memwb_data;
            else if (writes_reg(wbend_instr) && dest_of(wbend_instr) == src_reg[k])
                fwd_val[k] = wbend_data;
            else
                fwd_val[k] = src_val[k];
        end
    end

    assign val_a = fwd_val[0];
    assign val_b = fwd_val[1];

    logic [2:0] ld_dest;
    assign ld_dest = rb_of(idex_instr);
    assign stall = (op_of(idex_instr) == OP_LW) &&
                   ((reads_a(ifid_instr) && ra_of(ifid_instr) == ld_dest) ||
                    (reads_b(ifid_instr) && rb_of(ifid_instr) == ld_dest));

    logic load_hit;
    assign load_hit = (op_of(exmem_instr) == OP_LW) &&
                      ((reads_a(idex_instr) && ra_of(idex_instr) == rb_of(exmem_instr)) ||
                       (reads_b(idex_instr) && rb_of(idex_instr) == rb_of(exmem_instr)));

    AST_LOAD_NEVER_BYPASSED: assert property (@(posedge clk) disable iff (!rst_n) !load_hit); // R5

endmodule

// File: rtl/core_alu.sv
module core_alu
    import pipe5_pkg::*;
(
    input  op_e         op,
    input  logic [31:0] a,
    input  logic [31:0] b,
    input  logic [31:0] offs,
    input  logic [31:0] pc1,
    output logic [31:0] result,
    output logic [31:0] target
);

    always_comb begin
        unique case (op)
            OP_ADD:       result = a + b;
            OP_NOR:       result = ~(a | b);
            OP_LW, OP_SW: result = a + offs;
            OP_BEQ:       result = {31'd0, a == b};
            default:      result = '0;
        endcase
    end

    assign target = pc1 + offs;

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int MEM_AW = 6,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_we,
    input  logic              prog_dmem,
    input  logic [MEM_AW-1:0] prog_addr,
    input  logic [31:0]       prog_wdata,
    input  logic [1:0]        dbg_sel,
    input  logic [MEM_AW-1:0] dbg_addr,
    output logic [31:0]       dbg_rdata,
    output logic              halted,
    output logic [CNT_W-1:0]  cycle_count
);

    localparam ifid_t  IFID_NOP  = '{instr: NOOP_WORD, pc1: '0};
    localparam idex_t  IDEX_NOP  = '{instr: NOOP_WORD, pc1: '0, rega: '0, regb: '0, offs: '0};
    localparam exmem_t EXMEM_NOP = '{instr: NOOP_WORD, target: '0, alu: '0, regb: '0};
    localparam wb_t    WB_NOP    = '{instr: NOOP_WORD, wdata: '0};

    core_state_e state_q, state_d;
    logic        run;
    logic [MEM_AW-1:0] pc_q;
    ifid_t  ifid_q;
    idex_t  idex_q;
    exmem_t exmem_q;
    wb_t    memwb_q, wbend_q;

    logic [31:0] fetch_word, rd_a, rd_b, reg_dbg, imem_dbg, dmem_dbg;
    logic [31:0] val_a, val_b, alu_res, br_target, mem_rdata, mem_wdata;
    logic        stall, taken, halt_ahead, wb_is_halt, core_sw;

    assign run        = (state_q == ST_RUN);
    assign taken      = (op_of(exmem_q.instr) == OP_BEQ) && exmem_q.alu[0];
    assign wb_is_halt = (op_of(memwb_q.instr) == OP_HALT);
    assign halt_ahead = (op_of(ifid_q.instr) == OP_HALT) || (op_of(idex_q.instr) == OP_HALT) ||
                        (op_of(exmem_q.instr) == OP_HALT) || wb_is_halt;
    assign core_sw    = run && (op_of(exmem_q.instr) == OP_SW);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  state_d = wb_is_halt ? ST_HALT : ST_RUN;
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // outputs
    always_comb begin
        halted = (state_q == ST_HALT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cycle_count <= '0;
        else if (run) cycle_count <= cycle_count + CNT_W'(1);
    end

    core_ram #(.AW(MEM_AW)) u_imem (
        .clk(clk), .we(prog_we && !rst_n && !prog_dmem), .waddr(prog_addr), .wdata(prog_wdata),
        .raddr(pc_q), .rdata(fetch_word), .daddr(dbg_addr), .ddata(imem_dbg)
    );

    core_ram #(.AW(MEM_AW)) u_dmem (
        .clk(clk), .we(core_sw || (prog_we && !rst_n && prog_dmem)),
        .waddr(core_sw ? exmem_q.alu[MEM_AW-1:0] : prog_addr),
        .wdata(core_sw ? exmem_q.regb : prog_wdata),
        .raddr(exmem_q.alu[MEM_AW-1:0]), .rdata(mem_rdata),
        .daddr(dbg_addr), .ddata(dmem_dbg)
    );

    core_regfile u_regs (
        .clk(clk), .rst_n(rst_n),
        .we(run && writes_reg(memwb_q.instr)), .waddr(dest_of(memwb_q.instr)), .wdata(memwb_q.wdata),
        .ra_a(ra_of(ifid_q.instr)), .rd_a(rd_a),
        .ra_b(rb_of(ifid_q.instr)), .rd_b(rd_b),
        .ra_d(dbg_addr[2:0]), .rd_d(reg_dbg)
    );

    core_hazard u_haz (
        .clk(clk), .rst_n(rst_n),
        .ifid_instr(ifid_q.instr), .idex_instr(idex_q.instr),
        .idex_rega(idex_q.rega), .idex_regb(idex_q.regb),
        .exmem_instr(exmem_q.instr), .exmem_alu(exmem_q.alu),
        .memwb_instr(memwb_q.instr), .memwb_data(memwb_q.wdata),
        .wbend_instr(wbend_q.instr), .wbend_data(wbend_q.wdata),
        .val_a(val_a), .val_b(val_b), .stall(stall)
    );

    core_alu u_alu (
        .op(op_of(idex_q.instr)), .a(val_a), .b(val_b), .offs(idex_q.offs), .pc1(idex_q.pc1),
        .result(alu_res), .target(br_target)
    );

    assign mem_wdata = (op_of(exmem_q.instr) == OP_LW) ? mem_rdata : exmem_q.alu;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= '0;
            ifid_q  <= IFID_NOP;
            idex_q  <= IDEX_NOP;
            exmem_q <= EXMEM_NOP;
            memwb_q <= WB_NOP;
            wbend_q <= WB_NOP;
        end else if (run) begin
            wbend_q <= memwb_q;
            memwb_q <= '{instr: exmem_q.instr, wdata: mem_wdata};
            if (taken) begin
                exmem_q <= EXMEM_NOP;
                idex_q  <= IDEX_NOP;
                ifid_q  <= IFID_NOP;
                pc_q    <= exmem_q.target[MEM_AW-1:0];
            end else begin
                exmem_q <= '{instr: idex_q.instr, target: br_target, alu: alu_res, regb: val_b};
                if (stall) begin
                    idex_q <= IDEX_NOP;
                end else begin
                    idex_q <= '{instr: ifid_q.instr, pc1: ifid_q.pc1, rega: rd_a, regb: rd_b,
                                offs: sext16(ifid_q.instr)};
                    if (halt_ahead) begin
                        ifid_q <= IFID_NOP;
                    end else begin
                        ifid_q <= '{instr: fetch_word, pc1: 32'(pc_q) + 32'd1};
                        pc_q   <= pc_q + 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        unique case (dbg_sel)
            2'd0:    dbg_rdata = reg_dbg;
            2'd1:    dbg_rdata = dmem_dbg;
            2'd2:    dbg_rdata = imem_dbg;
            default: dbg_rdata = '0;
        endcase
    end

    logic unused_bits;
    assign unused_bits = ^{ifid_q, idex_q, exmem_q, wbend_q.instr, dbg_addr};

    AST_FLUSH_THREE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && taken) |=> (op_of(ifid_q.instr) == OP_NOOP && op_of(idex_q.instr) == OP_NOOP &&
                            op_of(exmem_q.instr) == OP_NOOP)); // R6
    AST_STALL_ONE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && stall && !taken) |=> ($stable(pc_q) && op_of(idex_q.instr) == OP_NOOP)); // R5
    AST_HALT_FROM_WB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(wb_is_halt)); // R7
    AST_FROZEN_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(pc_q) && $stable(cycle_count))); // R8
    AST_NO_STORE_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(memwb_q)); // R7

endmodule

// File: tb/sim_pipe5_core.sv
module sim_pipe5_core;

    localparam int AW = 6;
    localparam logic [31:0] HALT_W = 32'h0180_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_we = 1'b0;
    logic          prog_dmem = 1'b0;
    logic [AW-1:0] prog_addr = '0;
    logic [31:0]   prog_wdata = '0;
    logic [1:0]    dbg_sel = '0;
    logic [AW-1:0] dbg_addr = '0;
    logic [31:0]   dbg_rdata;
    logic          halted;
    logic [31:0]   cycle_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pipe5_core #(.MEM_AW(AW), .CNT_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_dmem(prog_dmem),
        .prog_addr(prog_addr), .prog_wdata(prog_wdata), .dbg_sel(dbg_sel),
        .dbg_addr(dbg_addr), .dbg_rdata(dbg_rdata), .halted(halted), .cycle_count(cycle_count)
    );

    // final-state table for program A: tag, sel, addr, expected
    localparam int NV = 14;
    localparam logic [43:0] VEC [NV] = '{
        {4'd3, 2'd0, 6'd1,  32'h0000_0007},  // R3 lw
        {4'd3, 2'd0, 6'd2,  32'hFFFF_FFFD},  // R3 lw
        {4'd5, 2'd0, 6'd3,  32'h0000_0004},  // R5 add after load bubble
        {4'd2, 2'd0, 6'd4,  32'hFFFF_FFF8},  // R2 nor
        {4'd4, 2'd0, 6'd5,  32'hFFFF_FFFC},  // R4 distance 1 and 2
        {4'd4, 2'd0, 6'd6,  32'h0000_0008},  // R4 distance 3
        {4'd3, 2'd0, 6'd7,  32'hFFFF_FFF8},  // R3
        {4'd2, 2'd0, 6'd0,  32'h0000_0000},  // R2
        {4'd3, 2'd1, 6'd20, 32'hFFFF_FFF8},  // R3 sw
        {4'd6, 2'd1, 6'd21, 32'h0000_0000},  // R6 flushed store
        {4'd5, 2'd1, 6'd22, 32'h0000_0008},  // R5 sw after load bubble
        {4'd9, 2'd1, 6'd5,  32'h0000_0055},  // R9 write while running ignored
        {4'd10, 2'd2, 6'd13, HALT_W},        // R10 imem read
        {4'd10, 2'd3, 6'd1, 32'h0000_0000}   // R10 unused select
    };

    function automatic logic [31:0] enc(input int op, input int a, input int b, input int low);
        return (32'(op) << 22) | (32'(a) << 19) | (32'(b) << 16) | (32'(low) & 32'h0000_FFFF);
    endfunction

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(input logic d, input int a, input logic [31:0] w);
        prog_we = 1'b1; prog_dmem = d; prog_addr = AW'(a); prog_wdata = w;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic peek(input int sel, input int a, output logic [31:0] v);
        dbg_sel = 2'(sel); dbg_addr = AW'(a);
        #1;
        v = dbg_rdata;
    endtask

    task automatic run_to_halt(output int n);
        n = 0;
        rst_n = 1'b1;
        while (!halted && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        check(1, 32'(halted), 32'd0);
        check(1, cycle_count, 32'd0);
        peek(0, 3, v); check(1, v, 32'd0);

        // program A
        put(0, 0,  enc(2, 0, 1, 10));
        put(0, 1,  enc(2, 0, 2, 11));
        put(0, 2,  enc(0, 1, 2, 3));
        put(0, 3,  enc(1, 3, 1, 4));
        put(0, 4,  enc(0, 3, 4, 5));
        put(0, 5,  enc(0, 3, 3, 6));
        put(0, 6,  enc(3, 0, 4, 20));
        put(0, 7,  enc(4, 1, 3, 5));
        put(0, 8,  enc(4, 6, 6, 2));
        put(0, 9,  enc(0, 1, 1, 7));
        put(0, 10, enc(3, 0, 1, 21));
        put(0, 11, enc(2, 0, 7, 20));
        put(0, 12, enc(3, 7, 6, 30));
        put(0, 13, HALT_W);
        put(0, 14, enc(0, 1, 1, 1));
        put(1, 10, 32'h0000_0007);
        put(1, 11, 32'hFFFF_FFFD);
        put(1, 21, 32'h0000_0000);
        put(1, 5,  32'h0000_0055);
        peek(2, 2, v); check(10, v, enc(0, 1, 2, 3));

        fork
            run_to_halt(n);
            begin
                repeat (3) @(negedge clk);
                put(1, 5, 32'h0000_00AA);
            end
        join
        // R8: 13 + 5 edges, plus 2 load bubbles, plus 3 flush, minus 2 skipped
        check(8, 32'(n), 32'd21);
        check(8, cycle_count, 32'd21);
        check(7, 32'(halted), 32'd1);
        repeat (5) @(negedge clk);
        check(8, cycle_count, 32'd21);

        for (int i = 0; i < NV; i++) begin
            peek(int'(VEC[i][39:38]), int'(VEC[i][37:32]), v);
            check(int'(VEC[i][43:40]), v, VEC[i][31:0]);
        end
        peek(0, 1, v); check(7, v, 32'h0000_0007);  // R7 add after halt never runs

        // program B: taken branch over a halt, negative offset, code 101
        rst_n = 1'b0;
        @(negedge clk);
        peek(0, 6, v); check(1, v, 32'd0);
        check(1, cycle_count, 32'd0);
        put(0, 0, enc(4, 0, 0, 1));
        put(0, 1, HALT_W);
        put(0, 2, enc(1, 0, 0, 1));
        put(0, 3, enc(3, 0, 1, -2));
        put(0, 4, enc(5, 0, 0, 1));
        put(0, 5, HALT_W);
        put(1, 62, 32'h0000_0000);
        run_to_halt(n);
        check(6, 32'(n), 32'd12);   // R6 shadowed halt flushed
        peek(0, 1, v); check(2, v, 32'hFFFF_FFFF);  // R2 nor, code 101 writes nothing
        peek(1, 62, v); check(3, v, 32'hFFFF_FFFF); // R3 negative offset wraps

        // program C: halt first
        rst_n = 1'b0;
        @(negedge clk);
        put(0, 0, HALT_W);
        run_to_halt(n);
        check(7, 32'(n), 32'd5);
        check(8, cycle_count, 32'd5);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule